// File: doc/BRIEF.md
# Memory Read Request Splitter

This block takes one large memory read job, given as a byte start address and a byte length, and cuts it into a stream of read requests that a request formatter can send as they are. Each request gives a dword-aligned address, a length in dwords, a byte-enable mask for the first dword and another for the last dword, and a flag that says whether the address needs the 64-bit address header format. Jobs arrive on a valid/ready handshake, and requests leave on a second one.

Each request is kept within two limits. It never crosses a 4096-byte address page, and its dword span never exceeds the maximum read size chosen by a 3-bit code. A start or end address that is not dword aligned is expressed through the byte enables. The size code is captured when the job is accepted, so later changes on that input do not affect a job that is already running. One request can be handed off in every clock cycle.

Top module: `rd_req_splitter`

## Requirements
- R1: No request covers bytes on both sides of a 4096-byte address boundary, so `req_addr[11:0] + 4*req_len_dw <= 4096`.
- R2: Each request spans at most `128 << code` bytes, counted as 4*req_len_dw, where code is the size code captured at job acceptance. Codes 0 to 5 give 128 to 4096 bytes. Codes 6 and 7 are treated as 4096.
- R3: `req_addr` always has bits [1:0] equal to zero. The first request carries the job address rounded down to a dword, and each later request starts at the byte that follows the previous one.
- R4: The payload bytes of a request are the smallest of three values: the job bytes still unsent, the bytes left to the next 4096-byte boundary, and the size limit minus the start byte offset within the dword. Requests come out in ascending address order, and their byte counts add up to the job length.
- R5: In `req_first_be`, bit i (bit 0 is the lowest address) is set only when byte i of the first dword is part of the job. In a request of two or more dwords, `req_last_be` marks the bytes of the last dword that are part of the job, in the same bit order. In a one-dword request, `req_last_be` is 0000 and `req_first_be` masks both ends.
- R6: `req_wide` is 1 when the request address is at or above 2^32, meaning the 64-bit address header format (Fmt 001, Type 00000) applies. Otherwise it is 0, meaning the 32-bit format (Fmt 000).
- R7: While `req_valid` is high and `req_ready` is low, `req_valid` and every request field hold their values. A request advances only on a handshake.
- R8: `job_ready` is high only when no job is in progress. The cycle after the last request handshake it is high again, and changes on `size_code` after acceptance have no effect on the running job.
- R9: A job whose length is zero is consumed on its handshake, and no request is produced for it.
- R10: After reset, `req_valid` is 0 and `job_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| job_valid | input | 1 | Job offered |
| job_ready | output | 1 | Splitter idle and able to take a job |
| job_addr | input | ADDR_W | Byte start address of the job |
| job_len | input | LEN_W | Job length in bytes |
| size_code | input | 3 | Maximum request size code, 128 << code bytes |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Downstream takes the request |
| req_addr | output | ADDR_W | Dword-aligned request address |
| req_len_dw | output | 11 | Request length in dwords (1 to 1024) |
| req_first_be | output | 4 | Byte enables of the first dword |
| req_last_be | output | 4 | Byte enables of the last dword, 0000 for one-dword requests |
| req_wide | output | 1 | 64-bit address format needed |

## Verification
The bench aims at jobs that start a few bytes before a page end. A splitter that clips only on the size limit would issue a request straddling the page, and one that forgets the start offset would issue a request one dword too long. One-byte and one-dword jobs are exercised to catch a splitter that places the end mask in the last-dword field or leaves that field nonzero. Codes 6 and 7, addresses just above 4 GB, zero-length jobs and a size code changed during a job are also driven. These cases expose unclamped size decoding, a wrong format flag, phantom requests, and a code that is read live instead of being captured. Random stalls on the request side catch fields that move before the handshake.

// File: rtl/rds_pkg.sv
package rds_pkg;
  localparam int PAGE_BYTES = 4096;
  localparam int PAGE_BITS  = 12;
  localparam int CHUNK_W    = PAGE_BITS + 1;
  localparam int DWCNT_W    = PAGE_BITS - 1;
  localparam int MAX_CODE   = 5;
  localparam int MIN_BYTES  = 128;
endpackage

// File: rtl/rds_size_decode.sv
module rds_size_decode
  import rds_pkg::*;
(
  input  logic [2:0]         code,
  output logic [CHUNK_W-1:0] max_bytes
);
  logic [2:0] sel;

  always_comb begin
    sel       = (code > 3'(MAX_CODE)) ? 3'(MAX_CODE) : code;
    max_bytes = CHUNK_W'(MIN_BYTES) << sel;
  end
endmodule

// File: rtl/rds_chunk_calc.sv
module rds_chunk_calc
  import rds_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32
) (
  input  logic [ADDR_W-1:0]  cur_addr,
  input  logic [LEN_W-1:0]   remain,
  input  logic [2:0]         code,
  output logic [CHUNK_W-1:0] chunk,
  output logic [DWCNT_W-1:0] len_dw,
  output logic [3:0]         first_be,
  output logic [3:0]         last_be
);
  logic [CHUNK_W-1:0] max_bytes;
  logic [CHUNK_W-1:0] page_left;
  logic [CHUNK_W-1:0] size_left;
  logic [CHUNK_W-1:0] bound;
  logic [CHUNK_W:0]   span;
  logic [1:0]         start_off;
  logic [1:0]         end_off;
  logic [3:0]         head_mask;
  logic [3:0]         tail_mask;
  logic               rem_small;

  rds_size_decode u_size (
    .code      (code),
    .max_bytes (max_bytes)
  );

  always_comb begin
    start_off = cur_addr[1:0];
    page_left = CHUNK_W'(PAGE_BYTES) - {1'b0, cur_addr[PAGE_BITS-1:0]};
    size_left = max_bytes - CHUNK_W'(start_off);
    bound     = (page_left < size_left) ? page_left : size_left;
    rem_small = (remain < LEN_W'(bound));
    chunk     = rem_small ? remain[CHUNK_W-1:0] : bound;
    span      = (CHUNK_W+1)'(start_off) + {1'b0, chunk} + (CHUNK_W+1)'(3);
    len_dw    = span[CHUNK_W-1:2];
    end_off   = start_off + chunk[1:0] - 2'd1;
    head_mask = 4'b1111 << start_off;
    tail_mask = 4'b1111 >> (2'd3 - end_off);
    if (len_dw == DWCNT_W'(1)) begin
      first_be = head_mask & tail_mask;
      last_be  = 4'b0000;
    end else begin
      first_be = head_mask;
      last_be  = tail_mask;
    end
  end
endmodule

// File: rtl/rd_req_splitter.sv
module rd_req_splitter
  import rds_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               job_valid,
  output logic               job_ready,
  input  logic [ADDR_W-1:0]  job_addr,
  input  logic [LEN_W-1:0]   job_len,
  input  logic [2:0]         size_code,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [DWCNT_W-1:0] req_len_dw,
  output logic [3:0]         req_first_be,
  output logic [3:0]         req_last_be,
  output logic               req_wide
);
  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [2:0]        code_q, code_d;
  logic [CHUNK_W-1:0] chunk;
  logic              take_job, take_req;

  rds_chunk_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_calc (
    .cur_addr (addr_q),
    .remain   (rem_q),
    .code     (code_q),
    .chunk    (chunk),
    .len_dw   (req_len_dw),
    .first_be (req_first_be),
    .last_be  (req_last_be)
  );

  assign job_ready = ~busy_q;
  assign req_valid = busy_q;
  assign req_addr  = {addr_q[ADDR_W-1:2], 2'b00};
  assign take_job  = job_valid & ~busy_q & (job_len != '0);
  assign take_req  = busy_q & req_ready;

  generate
    if (ADDR_W > 32) begin : g_wide
      assign req_wide = |addr_q[ADDR_W-1:32];
    end else begin : g_narrow
      assign req_wide = 1'b0;
    end
  endgenerate

  always_comb begin
    busy_d = busy_q;
    addr_d = addr_q;
    rem_d  = rem_q;
    code_d = code_q;
    if (take_job) begin
      busy_d = 1'b1;
      addr_d = job_addr;
      rem_d  = job_len;
      code_d = size_code;
    end else if (take_req) begin
      addr_d = addr_q + ADDR_W'(chunk);
      rem_d  = rem_q - LEN_W'(chunk);
      busy_d = (rem_q != LEN_W'(chunk));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
      code_q <= '0;
    end else begin
      busy_q <= busy_d;
      if (take_job || take_req) begin
        addr_q <= addr_d;
        rem_q  <= rem_d;
      end
      if (take_job) begin
        code_q <= code_d;
      end
    end
  end
endmodule

// File: rtl/rds_checker.sv
module rds_checker
  import rds_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               job_valid,
  input logic               job_ready,
  input logic [LEN_W-1:0]   job_len,
  input logic               req_valid,
  input logic               req_ready,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [DWCNT_W-1:0] req_len_dw,
  input logic [3:0]         req_first_be,
  input logic [3:0]         req_last_be,
  input logic               req_wide,
  input logic [2:0]         code_q
);
  int lim_dw;
  always_comb lim_dw = 32 << ((code_q > 3'd5) ? 5 : int'(code_q));

  a_r1_page_fit: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(req_addr[11:0]) + 4 * int'(req_len_dw) <= PAGE_BYTES));

  a_r2_size_cap: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(req_len_dw) <= lim_dw) && (req_len_dw != '0));

  a_r3_dw_align: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[1:0] == 2'b00);

  a_r5_single_dw: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_len_dw == DWCNT_W'(1)) |-> (req_last_be == 4'b0000 && req_first_be != 4'b0000));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len_dw)
      && $stable(req_first_be) && $stable(req_last_be) && $stable(req_wide)));

  a_r8_one_job: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !job_ready);

  a_r9_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (job_valid && job_ready && job_len == '0) |=> !req_valid);
endmodule

bind rd_req_splitter rds_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_rds_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .job_valid    (job_valid),
  .job_ready    (job_ready),
  .job_len      (job_len),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_addr     (req_addr),
  .req_len_dw   (req_len_dw),
  .req_first_be (req_first_be),
  .req_last_be  (req_last_be),
  .req_wide     (req_wide),
  .code_q       (code_q)
);

// File: tb/rd_req_splitter_test.sv
`timescale 1ns/1ps
module rd_req_splitter_test;
  logic        clk;
  logic        rst_n;
  logic        job_valid;
  logic        job_ready;
  logic [63:0] job_addr;
  logic [31:0] job_len;
  logic [2:0]  size_code;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_addr;
  logic [10:0] req_len_dw;
  logic [3:0]  req_first_be;
  logic [3:0]  req_last_be;
  logic        req_wide;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  rd_req_splitter uut (
    .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_ready(job_ready),
    .job_addr(job_addr), .job_len(job_len), .size_code(size_code),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len_dw(req_len_dw), .req_first_be(req_first_be),
    .req_last_be(req_last_be), .req_wide(req_wide)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic run_job(input longint unsigned a, input longint unsigned n,
                         input logic [2:0] c);
    longint unsigned cur, rem, mx, pl, lim, ch, dw, e, s;
    logic [3:0] fm, lm, efb, elb;
    @(negedge clk);
    chk(job_ready == 1'b1, "R8 idle before job", job_ready, 1);
    job_valid = 1'b1; job_addr = a; job_len = 32'(n); size_code = c;
    @(negedge clk);
    job_valid = 1'b0;
    size_code = 3'($urandom);
    cur = a; rem = n;
    if (n == 0) begin
      chk(req_valid == 1'b0, "R9 zero length no request", req_valid, 0);
      chk(job_ready == 1'b1, "R9 zero length consumed", job_ready, 1);
    end
    while (rem > 0) begin
      mx  = 128 << ((c > 5) ? 5 : c);
      s   = cur & 3;
      pl  = 4096 - (cur & 12'hFFF);
      lim = mx - s;
      ch  = (pl < lim) ? pl : lim;
      if (rem < ch) ch = rem;
      dw  = (s + ch + 3) >> 2;
      e   = (cur + ch - 1) & 3;
      fm  = 4'(4'hF << s);
      lm  = 4'(4'hF >> (3 - e));
      if (dw == 1) begin efb = fm & lm; elb = 4'b0000; end
      else begin efb = fm; elb = lm; end
      for (int k = 0; k <= int'($urandom % 3); k++) begin
        req_ready = ($urandom % 3) == 0 ? 1'b0 : 1'b0;
        chk(req_valid == 1'b1, "R7 request valid", req_valid, 1);
        chk(job_ready == 1'b0, "R8 busy during job", job_ready, 0);
        chk(req_addr == (cur & ~64'h3), "R3 request address", req_addr, cur & ~64'h3);
        chk(req_len_dw == 11'(dw), "R4 length in dwords", req_len_dw, dw);
        chk((cur & 12'hFFF) + ch <= 4096, "R1 page fit", (cur & 12'hFFF) + ch, 4096);
        chk(4 * dw <= mx, "R2 size cap", 4 * dw, mx);
        chk(req_first_be == efb, "R5 first byte enables", req_first_be, efb);
        chk(req_last_be == elb, "R5 last byte enables", req_last_be, elb);
        chk(req_wide == (cur >= 64'h1_0000_0000), "R6 wide format flag", req_wide,
            cur >= 64'h1_0000_0000);
        if (k == 0) req_ready = 1'b0;
        @(negedge clk);
      end
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      cur = cur + ch;
      rem = rem - ch;
    end
    chk(req_valid == 1'b0, "R4 no request past job end", req_valid, 0);
    chk(job_ready == 1'b1, "R8 ready after last request", job_ready, 1);
  endtask

  initial begin
    rst_n = 1'b0; job_valid = 1'b0; job_addr = '0; job_len = '0;
    size_code = '0; req_ready = 1'b0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(req_valid == 1'b0, "R10 reset valid", req_valid, 0);
    chk(job_ready == 1'b1, "R10 reset ready", job_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_valid == 1'b0, "R10 after release", req_valid, 0);
    // directed corners
    run_job(64'h0000_0FFE, 8, 3'd0);         // R1 straddles a page
    run_job(64'h0000_0005, 1, 3'd2);         // R5 single byte
    run_job(64'h0000_0011, 3, 3'd1);         // R5 within one dword
    run_job(64'h0000_0000, 8192, 3'd7);      // R2 clamped code
    run_job(64'h0000_0000, 4096, 3'd6);      // R2 clamped code
    run_job(64'h0000_0003, 300, 3'd0);       // R2 offset trims first chunk
    run_job(64'h1_0000_0010, 300, 3'd0);     // R6 above 4GB
    run_job(64'h0_FFFF_FFF0, 40, 3'd1);      // R6 crosses 4GB line
    run_job(64'h0000_1234, 0, 3'd0);         // R9 zero length
    run_job(64'h0000_0102, 700, 3'd5);       // R8 code scrambled after accept
    // random jobs
    for (int j = 0; j < 60; j++) begin
      longint unsigned ra;
      ra = ($urandom % 4 == 0) ? {32'(($urandom % 8)), $urandom} : 64'($urandom);
      run_job(ra, 64'($urandom % 3000), 3'($urandom));
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule